// File: doc/BRIEF.md
# Keyed watchdog timer

A watchdog peripheral with a small memory-mapped register interface. Software arms it and keeps it alive by writing magic values into a key register. A down-counter decrements once per prescaled tick and raises a single-cycle reset request when it underflows. Once armed, the watchdog cannot be stopped by any software write. Only a hardware reset disarms it.

The divider code and reload value live in two configuration registers that only accept writes while a key-controlled unlock is open. While the watchdog runs, a configuration write does not take effect at once. It passes through a fixed synchronisation delay counted in prescaled ticks, and an update-pending flag in the status register shows that delay. A status flag also reports the armed state, and a read-only register reports a fixed version code. Software uses the version code to learn that the armed flag exists.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `reset_req` is 0, the status register reads 0, the reload register reads 0xFFF and the divider register reads 0.
- R2: Writing 0x0000CCCC (all 32 bits must match) to the key register at offset 0x00 arms the watchdog and sets status bit 8. No later key write or configuration write clears it.
- R3: With divider code c and reload value N written before arming, the first reset pulse appears D = 4·2^c·(N+1) cycles after the arming write. The pulse lasts exactly one cycle. The counter then reloads, and the next pulse follows D cycles later.
- R4: Key 0x00005555 opens configuration access. Any other key write closes it, 0x00000000 and unknown values included.
- R5: Writes to the divider register (offset 0x04) or the reload register (offset 0x08) while access is closed leave them unchanged.
- R6: Key 0x0000AAAA refreshes the counter from the active reload value, which defers the next pulse.
- R7: While the watchdog is armed, an accepted write to the divider register sets status bit 0, and an accepted write to the reload register sets status bit 1. This happens even if the new value equals the old one. The flag stays set for 2 prescaled ticks, then clears as the value takes effect. While the watchdog is disarmed, the write takes effect at once and the flag stays 0.
- R8: Divider codes above 6 act as code 6, which divides by 256.
- R9: The register at offset 0x3F4 reads 0x31.
- R10: The divider and reload registers read back the last accepted value. The key register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| reset_req | output | 1 | One-cycle reset request on counter underflow |

## Verification
The hardest cases to reach both need an armed watchdog. The update-pending flags can only be seen while the counter runs, and an armed watchdog cannot be disarmed. The stimulus therefore applies a hardware reset before each phase, configures while disarmed, arms, and then drives refreshes and configuration rewrites within the first reload period. It measures pulse spacing in cycles and compares it against the divider and reload products, including a code above the clamp.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int unsigned OFS_KEY  = 'h000;
   localparam int unsigned OFS_DIV  = 'h004;
   localparam int unsigned OFS_RLD  = 'h008;
   localparam int unsigned OFS_STAT = 'h00C;
   localparam int unsigned OFS_VER  = 'h3F4;

   localparam logic [15:0] KEY_ARM   = 16'hCCCC;
   localparam logic [15:0] KEY_FEED  = 16'hAAAA;
   localparam logic [15:0] KEY_OPEN  = 16'h5555;

   localparam int unsigned STAT_DIV_PEND = 0;
   localparam int unsigned STAT_RLD_PEND = 1;
   localparam int unsigned STAT_ARMED    = 8;
endpackage

// File: rtl/kwdt_key_ctrl.sv
module kwdt_key_ctrl #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed,
   output logic              unlocked,
   output logic              load_cnt
);
   import kwdt_pkg::*;

   logic is_arm, is_feed, is_open;

   assign is_arm  = (wdata == DATA_W'(KEY_ARM));
   assign is_feed = (wdata == DATA_W'(KEY_FEED));
   assign is_open = (wdata == DATA_W'(KEY_OPEN));

   // Counter loads on the first arming write and on every refresh.
   assign load_cnt = key_wr && (is_feed || (is_arm && !armed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         unlocked <= 1'b0;
      end else if (key_wr) begin
         armed    <= armed | is_arm;
         unlocked <= is_open;
      end
   end
endmodule

// File: rtl/kwdt_sync_reg.sv
module kwdt_sync_reg #(
   parameter int unsigned W          = 12,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter int unsigned SYNC_TICKS = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   input  logic         running,
   input  logic         tick,
   output logic [W-1:0] shadow,
   output logic [W-1:0] active,
   output logic         pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow <= RST_VAL;
      else if (wr) shadow <= din;
   end

   generate
      if (SYNC_TICKS == 0) begin : g_direct
         assign active  = shadow;
         assign pending = 1'b0;
      end else begin : g_synced
         localparam int unsigned SW = $clog2(SYNC_TICKS + 1);
         logic [SW-1:0] sync_cnt;
         logic [W-1:0]  act_q;
         logic          pend_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q    <= RST_VAL;
               pend_q   <= 1'b0;
               sync_cnt <= '0;
            end else if (wr && running) begin
               pend_q   <= 1'b1;
               sync_cnt <= SW'(SYNC_TICKS);
            end else if (wr) begin
               act_q    <= din;
            end else if (pend_q && tick) begin
               if (sync_cnt == SW'(1)) begin
                  pend_q <= 1'b0;
                  act_q  <= shadow;
               end
               sync_cnt <= sync_cnt - 1'b1;
            end
         end
         assign active  = act_q;
         assign pending = pend_q;
      end
   endgenerate
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
   parameter int unsigned PR_W      = 3,
   parameter int unsigned MAX_CODE  = 6,
   parameter int unsigned BASE_LOG2 = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PR_W-1:0] code,
   output logic            tick
);
   localparam int unsigned DIV_W = BASE_LOG2 + MAX_CODE;

   generate
      if (MAX_CODE > (2 ** PR_W) - 1) begin : g_bad_code
         $error("kwdt_prescale: MAX_CODE does not fit in PR_W bits");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("kwdt_prescale: divider width must be positive");
      end
   endgenerate

   logic [PR_W-1:0]  code_eff;
   logic [DIV_W-1:0] limit;
   logic [DIV_W-1:0] div_cnt;

   generate
      if ((2 ** PR_W) - 1 > MAX_CODE) begin : g_clamp
         assign code_eff = (code > PR_W'(MAX_CODE)) ? PR_W'(MAX_CODE) : code;
      end else begin : g_full
         assign code_eff = code;
      end
   endgenerate

   // Divide by 2^(BASE_LOG2+code): terminal count is a run of ones.
   assign limit = {DIV_W{1'b1}} >> (MAX_CODE - int'(code_eff));
   assign tick  = run && (div_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_cnt <= '0;
      else if (!run)   div_cnt <= '0;
      else if (tick)   div_cnt <= '0;
      else             div_cnt <= div_cnt + 1'b1;
   end
endmodule

// File: rtl/kwdt_downcnt.sv
module kwdt_downcnt #(
   parameter int unsigned RL_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            tick,
   input  logic [RL_W-1:0] reload,
   output logic            reset_req
);
   logic [RL_W-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '1;
         reset_req <= 1'b0;
      end else begin
         reset_req <= 1'b0;
         if (load) begin
            count <= reload;
         end else if (tick) begin
            if (count == '0) begin
               count     <= reload;
               reset_req <= 1'b1;
            end else begin
               count <= count - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RL_W       = 12,
   parameter int unsigned PR_W       = 3,
   parameter int unsigned MAX_CODE   = 6,
   parameter int unsigned BASE_LOG2  = 2,
   parameter int unsigned SYNC_TICKS = 2,
   parameter logic [31:0] VERSION    = 32'h31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              reset_req
);
   import kwdt_pkg::*;

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("keyed_watchdog: ADDR_W too small for the version offset");
      end
      if (DATA_W < 16 || DATA_W < RL_W || DATA_W <= STAT_ARMED) begin : g_bad_data
         $error("keyed_watchdog: DATA_W too narrow");
      end
      if (DATA_W < 32) begin : g_bad_ver
         $error("keyed_watchdog: DATA_W must hold the version word");
      end
   endgenerate

   logic sel_key, sel_div, sel_rld, sel_stat, sel_ver;
   logic armed, unlocked, load_cnt, tick;
   logic div_pend, rld_pend;
   logic [PR_W-1:0] div_shadow, div_active;
   logic [RL_W-1:0] rl_shadow, rl_active;

   assign sel_key  = (addr == ADDR_W'(OFS_KEY));
   assign sel_div  = (addr == ADDR_W'(OFS_DIV));
   assign sel_rld  = (addr == ADDR_W'(OFS_RLD));
   assign sel_stat = (addr == ADDR_W'(OFS_STAT));
   assign sel_ver  = (addr == ADDR_W'(OFS_VER));

   kwdt_key_ctrl #(.DATA_W(DATA_W)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wr_en && sel_key),
      .wdata    (wdata),
      .armed    (armed),
      .unlocked (unlocked),
      .load_cnt (load_cnt)
   );

   kwdt_sync_reg #(.W(PR_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_div_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en && sel_div && unlocked),
      .din     (wdata[PR_W-1:0]),
      .running (armed),
      .tick    (tick),
      .shadow  (div_shadow),
      .active  (div_active),
      .pending (div_pend)
   );

   kwdt_sync_reg #(.W(RL_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en && sel_rld && unlocked),
      .din     (wdata[RL_W-1:0]),
      .running (armed),
      .tick    (tick),
      .shadow  (rl_shadow),
      .active  (rl_active),
      .pending (rld_pend)
   );

   kwdt_prescale #(.PR_W(PR_W), .MAX_CODE(MAX_CODE), .BASE_LOG2(BASE_LOG2)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (armed),
      .code  (div_active),
      .tick  (tick)
   );

   kwdt_downcnt #(.RL_W(RL_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_cnt),
      .tick      (tick),
      .reload    (rl_active),
      .reset_req (reset_req)
   );

   always_comb begin
      rdata = '0;
      if (sel_div) begin
         rdata[PR_W-1:0] = div_shadow;
      end else if (sel_rld) begin
         rdata[RL_W-1:0] = rl_shadow;
      end else if (sel_stat) begin
         rdata[STAT_DIV_PEND] = div_pend;
         rdata[STAT_RLD_PEND] = rld_pend;
         rdata[STAT_ARMED]    = armed;
      end else if (sel_ver) begin
         rdata = DATA_W'(VERSION);
      end
   end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned RL_W    = 12,
   parameter logic [31:0] VERSION = 32'h31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              reset_req,
   input logic              armed,
   input logic              unlocked,
   input logic [RL_W-1:0]   rl_shadow,
   input logic              div_pend,
   input logic              rld_pend
);
   import kwdt_pkg::*;

   assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   assert_req_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> armed);

   assert_req_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_KEY) && wdata != DATA_W'(KEY_OPEN)) |=> !unlocked);

   assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_RLD) && !unlocked) |=> $stable(rl_shadow));

   assert_no_pend_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !(div_pend || rld_pend));

   assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_VER)) |-> (rdata == DATA_W'(VERSION)));
endmodule

bind keyed_watchdog kwdt_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RL_W(RL_W), .VERSION(VERSION)
) u_kwdt_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .reset_req (reset_req),
   .armed     (armed),
   .unlocked  (unlocked),
   .rl_shadow (rl_shadow),
   .div_pend  (div_pend),
   .rld_pend  (rld_pend)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        reset_req;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   keyed_watchdog u_keyed_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .reset_req (reset_req)
   );

   // {code[7:0], reload[11:0], expected period[11:0]}
   localparam int NV = 5;
   localparam logic [31:0] VEC [NV] = '{
      {8'd0, 12'd5, 12'd24},
      {8'd2, 12'd3, 12'd64},
      {8'd6, 12'd1, 12'd512},
      {8'd7, 12'd1, 12'd512},
      {8'd1, 12'd0, 12'd8}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!reset_req && n < 3000);
   endtask

   initial begin
      int n;
      logic [31:0] r;

      do_reset();
      chk("R1 reset_req", {31'd0, reset_req}, 32'd0);
      rd(12'h00C, r); chk("R1 status", r, 32'h0);
      rd(12'h008, r); chk("R1 reload", r, 32'hFFF);
      rd(12'h004, r); chk("R1 divider", r, 32'h0);
      rd(12'h3F4, r); chk("R9 version", r, 32'h31);
      rd(12'h000, r); chk("R10 key reads 0", r, 32'h0);
      rd(12'h010, r); chk("R10 unmapped", r, 32'h0);

      // Access control
      wr(12'h008, 32'h123);
      rd(12'h008, r); chk("R5 locked reload", r, 32'hFFF);
      wr(12'h004, 32'h3);
      rd(12'h004, r); chk("R5 locked divider", r, 32'h0);
      wr(12'h000, 32'h5555);
      wr(12'h000, 32'h1234);
      wr(12'h008, 32'h456);
      rd(12'h008, r); chk("R4 unknown key relocks", r, 32'hFFF);
      wr(12'h000, 32'h5555);
      wr(12'h008, 32'h456);
      rd(12'h008, r); chk("R4 open accepts", r, 32'h456);
      wr(12'h004, 32'h3);
      rd(12'h004, r); chk("R10 divider readback", r, 32'h3);
      rd(12'h00C, r); chk("R7 idle write no flag", r, 32'h0);
      wr(12'h000, 32'h0000);
      wr(12'h008, 32'h789);
      rd(12'h008, r); chk("R4 zero key relocks", r, 32'h456);

      // Period table
      for (int i = 0; i < NV; i++) begin
         logic [31:0] v;
         v = VEC[i];
         do_reset();
         wr(12'h000, 32'h5555);
         wr(12'h004, {24'd0, v[31:24]});
         wr(12'h008, {20'd0, v[23:12]});
         wr(12'h000, 32'h0000);
         wr(12'h000, 32'hCCCC);
         rd(12'h00C, r); chk("R2 armed flag", r, 32'h100);
         wait_pulse(n);
         chk((v[31:24] > 6) ? "R8 clamp first pulse" : "R3 first pulse", n, {20'd0, v[11:0]});
         @(negedge clk);
         chk("R3 one cycle", {31'd0, reset_req}, 32'd0);
         wait_pulse(n);
         chk("R3 repeat period", n, {20'd0, v[11:0]} - 1);
      end

      // Sticky arm, refresh, pending updates
      do_reset();
      wr(12'h000, 32'h5555);
      wr(12'h008, 32'd5);
      wr(12'h000, 32'h0000);
      wr(12'h000, 32'hCCCC);
      wr(12'h000, 32'h0000);
      wr(12'h000, 32'hBEEF);
      rd(12'h00C, r); chk("R2 cannot stop", r, 32'h100);
      wr(12'h000, 32'hAAAA);
      wait_pulse(n);
      chk_rng("R6 refresh defers", n, 21, 24);
      wr(12'h000, 32'h5555);
      wr(12'h008, 32'd9);
      rd(12'h00C, r); chk("R7 reload pending", r, 32'h102);
      wr(12'h004, 32'd0);
      rd(12'h00C, r); chk("R7 divider pending same value", r, 32'h103);
      repeat (9) @(negedge clk);
      rd(12'h00C, r); chk("R7 flags cleared", r, 32'h100);
      wr(12'h000, 32'hAAAA);
      wait_pulse(n);
      chk_rng("R7 new reload in effect", n, 37, 40);
      rd(12'h008, r); chk("R10 reload readback", r, 32'd9);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule